// File: doc/BRIEF.md
# Next-Hop Adjacency Table

This block stores the router's next-hop entries. Each entry carries a valid flag, a hit-activity flag, an egress router interface number, a trap action, a trap reason and a 48-bit destination MAC. Management software reaches the table through a request/response port. That port can read an entry, read it while clearing its activity flag, write it unconditionally, or write it only when the entry has seen no traffic since its activity flag was last cleared. The fourth operation lets software replace an idle next-hop without a race against live traffic. After a conditional write, software reads the entry back to learn whether the write took effect.

A separate lookup port takes an index and returns the stored entry one cycle later. A hit marks the entry active. An entry that is invalidated enters a timed quarantine before it can be used again. During the quarantine, every management access to that entry is answered with a retry status and has no other effect. A single shared down-counter times the quarantines one entry at a time. Further invalidations wait in a per-entry pending set until the counter is free.

Top module: `nh_adjacency_table`

## Requirements
- R1: The 4-bit opcode selects the operation: 0 reads, 2 reads and clears activity, 1 writes unconditionally, and 3 writes only when the entry's activity flag is clear. Any other opcode returns the error status and changes nothing.
- R2: Writing an entry with valid = 1 sets its activity flag, and a lookup hit also sets it. Only a successful read-and-clear clears it. Reads report the flag value from before any clearing.
- R3: A conditional write (opcode 3) to an active entry is dropped and still returns status ok. A later read shows the unchanged entry.
- R4: A write with valid = 0 to a valid entry starts a quarantine of QUAR_CYCLES cycles. During the quarantine, management accesses to that entry return status 1 (retry), return zero data and change nothing, and lookups of the entry miss.
- R5: A read of an entry whose valid flag is 0 returns zero in the interface, trap action, trap reason and MAC fields.
- R6: The entry index is {idx_hi[7:0], idx_lo[15:0]}. An index at or above DEPTH returns status 2 (error), and a lookup with such an index misses.
- R7: A write with valid = 1 whose interface number is at or above RIF_LIMIT returns status 2 and leaves the entry unchanged.
- R8: A lookup returns, one cycle later, hit = 1 with the stored fields when the entry is valid and not in quarantine. Otherwise it returns hit = 0 with all fields zero.
- R9: A request is accepted when req_valid and req_ready are both high. Exactly one cycle later, rsp_valid is high for one cycle with status 0 = ok, 1 = retry or 2 = error.
- R10: When a lookup hit and a read-and-clear target the same entry in the same cycle, the entry's activity flag ends up set.
- R11: Quarantines are timed one at a time. A second invalidation made while the first is being timed stays in retry until the first has ended and its own full window has elapsed.
- R12: A write with valid = 1 is rejected with status 2 when the trap action is above 4 (0 no-op, 1 trap, 2 mirror to CPU, 3 mirror, 4 discard errors) or the trap reason is above 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Management request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 4 | Operation code |
| req_idx_lo | input | 16 | Entry index, low part |
| req_idx_hi | input | 8 | Entry index, high part |
| req_entry_valid | input | 1 | Valid flag to write |
| req_rif | input | 16 | Egress router interface to write |
| req_trap_act | input | 4 | Trap action to write |
| req_trap_id | input | 8 | Trap reason to write |
| req_mac | input | 48 | Destination MAC to write |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 ok, 1 retry, 2 error |
| rsp_entry_valid | output | 1 | Valid flag read |
| rsp_active | output | 1 | Activity flag read (before clearing) |
| rsp_rif | output | 16 | Interface read |
| rsp_trap_act | output | 4 | Trap action read |
| rsp_trap_id | output | 8 | Trap reason read |
| rsp_mac | output | 48 | MAC read |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | 24 | Lookup index |
| lk_out_valid | output | 1 | Lookup result present |
| lk_hit | output | 1 | Entry valid and usable |
| lk_rif | output | 16 | Interface of hit entry |
| lk_trap_act | output | 4 | Trap action of hit entry |
| lk_trap_id | output | 8 | Trap reason of hit entry |
| lk_mac | output | 48 | MAC of hit entry |

## Verification
The bench drives a conditional write at an active entry. A design that ignores the activity flag would replace the interface number, and the following read catches it. It collides a lookup hit with a read-and-clear on the same entry, so a design with the wrong priority leaves the activity flag clear. It invalidates two entries back to back and probes both around the first window's end. A design that times windows in parallel, releases entries early or lets a retried write through would show an entry as accessible, or as valid, at the wrong moment. Out-of-range indices, an interface number exactly at the limit, an illegal trap action and an undefined opcode cover the error paths, where a design with an off-by-one check would answer ok.

// File: rtl/nh_pkg.sv
package nh_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_RETRY = 2'd1,
    ST_ERR   = 2'd2
  } nh_status_e;

  localparam logic [3:0] OP_READ     = 4'd0;
  localparam logic [3:0] OP_WRITE    = 4'd1;
  localparam logic [3:0] OP_READ_CLR = 4'd2;
  localparam logic [3:0] OP_WRITE_IDLE = 4'd3;

  localparam logic [3:0] TACT_LAST = 4'd4;
  localparam logic [7:0] TID_LAST  = 8'd1;

  typedef struct packed {
    logic [15:0] rif;
    logic [3:0]  tact;
    logic [7:0]  tid;
    logic [47:0] mac;
  } nh_data_t;
endpackage

// File: rtl/nh_store.sv
module nh_store
  import nh_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  nh_data_t      wdata,
  input  logic [AW-1:0] a_addr,
  output nh_data_t      a_data,
  input  logic [AW-1:0] b_addr,
  output nh_data_t      b_data
);
  nh_data_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_data <= mem[a_addr];
    b_data <= mem[b_addr];
  end
endmodule

// File: rtl/nh_quarantine.sv
module nh_quarantine #(
  parameter int DEPTH = 256,
  parameter int QUAR_CYCLES = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(QUAR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    start_idx,
  output logic [DEPTH-1:0] pend
);
  logic          busy;
  logic [AW-1:0] cur;
  logic [CW-1:0] cnt;
  logic [AW-1:0] nxt;
  logic          any;

  always_comb begin
    nxt = '0;
    any = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        nxt = i[AW-1:0];
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      busy <= 1'b0;
      cur  <= '0;
      cnt  <= '0;
    end else begin
      if (busy) begin
        if (cnt == '0) begin
          pend[cur] <= 1'b0;
          busy      <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (any) begin
        busy <= 1'b1;
        cur  <= nxt;
        cnt  <= CW'(QUAR_CYCLES - 1);
      end
      if (start) pend[start_idx] <= 1'b1;
    end
  end

  assert_busy_pending_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> pend[cur]);
  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(QUAR_CYCLES - 1));
endmodule

// File: rtl/nh_adjacency_table.sv
module nh_adjacency_table
  import nh_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int RIF_LIMIT = 1000,
  parameter int QUAR_CYCLES = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_op,
  input  logic [15:0] req_idx_lo,
  input  logic [7:0]  req_idx_hi,
  input  logic        req_entry_valid,
  input  logic [15:0] req_rif,
  input  logic [3:0]  req_trap_act,
  input  logic [7:0]  req_trap_id,
  input  logic [47:0] req_mac,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic        rsp_entry_valid,
  output logic        rsp_active,
  output logic [15:0] rsp_rif,
  output logic [3:0]  rsp_trap_act,
  output logic [7:0]  rsp_trap_id,
  output logic [47:0] rsp_mac,
  input  logic        lk_valid,
  input  logic [23:0] lk_index,
  output logic        lk_out_valid,
  output logic        lk_hit,
  output logic [15:0] lk_rif,
  output logic [3:0]  lk_trap_act,
  output logic [7:0]  lk_trap_id,
  output logic [47:0] lk_mac
);
  logic [DEPTH-1:0] vld, act, pend;
  logic [23:0]   req_idx;
  logic          req_in_rng, lk_in_rng, acc;
  logic [AW-1:0] ia, lk_ia;
  nh_status_e    st;
  logic          is_rd, wr_op, wr_go, rdclr_go, inval, lk_hit_now;
  nh_data_t      wdata, a_data, b_data;

  logic          rdy_q, rsp_v_q, rd_v_q, rd_a_q, lk_ov_q, lk_hit_q;
  nh_status_e    st_q;

  assign req_idx    = {req_idx_hi, req_idx_lo};
  assign req_in_rng = req_idx < 24'(DEPTH);
  assign ia         = req_idx[AW-1:0];
  assign lk_in_rng  = lk_index < 24'(DEPTH);
  assign lk_ia      = lk_index[AW-1:0];
  assign acc        = req_valid && rdy_q;

  assign is_rd = (req_op == OP_READ) || (req_op == OP_READ_CLR);
  assign wr_op = (req_op == OP_WRITE) || (req_op == OP_WRITE_IDLE);

  always_comb begin
    st = ST_OK;
    if (!req_in_rng) st = ST_ERR;
    else if (pend[ia]) st = ST_RETRY;
    else if (wr_op) begin
      if (req_entry_valid && (req_rif >= 16'(RIF_LIMIT) ||
          req_trap_act > TACT_LAST || req_trap_id > TID_LAST))
        st = ST_ERR;
    end else if (!is_rd) st = ST_ERR;
  end

  assign wr_go      = acc && (st == ST_OK) && wr_op &&
                      ((req_op == OP_WRITE) || !act[ia]);
  assign rdclr_go   = acc && (st == ST_OK) && (req_op == OP_READ_CLR);
  assign inval      = wr_go && !req_entry_valid && vld[ia];
  assign lk_hit_now = lk_valid && lk_in_rng && vld[lk_ia] && !pend[lk_ia];

  assign wdata = '{rif: req_rif, tact: req_trap_act, tid: req_trap_id, mac: req_mac};

  nh_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_go && req_entry_valid), .waddr(ia), .wdata(wdata),
    .a_addr(ia), .a_data(a_data), .b_addr(lk_ia), .b_data(b_data)
  );

  nh_quarantine #(.DEPTH(DEPTH), .QUAR_CYCLES(QUAR_CYCLES)) u_quar (
    .clk(clk), .rst(rst), .start(inval), .start_idx(ia), .pend(pend)
  );

  // Entry flags; the lookup update comes last so it wins over a clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      act <= '0;
    end else begin
      if (rdclr_go) act[ia] <= 1'b0;
      if (wr_go) begin
        vld[ia] <= req_entry_valid;
        act[ia] <= req_entry_valid;
      end
      if (lk_hit_now && !(inval && lk_ia == ia)) act[lk_ia] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q    <= 1'b0;
      rsp_v_q  <= 1'b0;
      st_q     <= ST_OK;
      rd_v_q   <= 1'b0;
      rd_a_q   <= 1'b0;
      lk_ov_q  <= 1'b0;
      lk_hit_q <= 1'b0;
    end else begin
      rdy_q    <= 1'b1;
      rsp_v_q  <= acc;
      st_q     <= acc ? st : ST_OK;
      rd_v_q   <= acc && (st == ST_OK) && is_rd && vld[ia];
      rd_a_q   <= acc && (st == ST_OK) && is_rd && act[ia];
      lk_ov_q  <= lk_valid;
      lk_hit_q <= lk_hit_now;
    end
  end

  assign req_ready       = rdy_q;
  assign rsp_valid       = rsp_v_q;
  assign rsp_status      = st_q;
  assign rsp_entry_valid = rd_v_q;
  assign rsp_active      = rd_a_q;
  assign rsp_rif         = rd_v_q ? a_data.rif  : '0;
  assign rsp_trap_act    = rd_v_q ? a_data.tact : '0;
  assign rsp_trap_id     = rd_v_q ? a_data.tid  : '0;
  assign rsp_mac         = rd_v_q ? a_data.mac  : '0;
  assign lk_out_valid    = lk_ov_q;
  assign lk_hit          = lk_hit_q;
  assign lk_rif          = lk_hit_q ? b_data.rif  : '0;
  assign lk_trap_act     = lk_hit_q ? b_data.tact : '0;
  assign lk_trap_id      = lk_hit_q ? b_data.tid  : '0;
  assign lk_mac          = lk_hit_q ? b_data.mac  : '0;

  assert_rsp_latency_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid && req_ready));
  assert_status_code_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_status != 2'd3);
  assert_retry_no_change_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && req_in_rng && pend[ia]) |=> vld[$past(ia)] == $past(vld[ia]));
  assert_rif_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_op && req_entry_valid && req_rif >= 16'(RIF_LIMIT)) |=> $stable(vld));
  assert_lookup_sets_act_R10: assert property (@(posedge clk) disable iff (rst)
    (lk_hit_now && !wr_go) |=> act[$past(lk_ia)]);
endmodule

// File: tb/nh_adjacency_table_test.sv
`timescale 1ns/1ps
module nh_adjacency_table_test;
  localparam int DEPTH = 256;
  localparam int RIF_LIMIT = 1000;
  localparam int Q = 64;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_op = '0;
  logic [15:0] req_idx_lo = '0;
  logic [7:0]  req_idx_hi = '0;
  logic        req_entry_valid = 1'b0;
  logic [15:0] req_rif = '0;
  logic [3:0]  req_trap_act = '0;
  logic [7:0]  req_trap_id = '0;
  logic [47:0] req_mac = '0;
  logic        rsp_valid, rsp_entry_valid, rsp_active;
  logic [1:0]  rsp_status;
  logic [15:0] rsp_rif;
  logic [3:0]  rsp_trap_act;
  logic [7:0]  rsp_trap_id;
  logic [47:0] rsp_mac;
  logic        lk_valid = 1'b0;
  logic [23:0] lk_index = '0;
  logic        lk_out_valid, lk_hit;
  logic [15:0] lk_rif;
  logic [3:0]  lk_trap_act;
  logic [7:0]  lk_trap_id;
  logic [47:0] lk_mac;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nh_adjacency_table #(.DEPTH(DEPTH), .RIF_LIMIT(RIF_LIMIT), .QUAR_CYCLES(Q)) uut (.*);

  task automatic chk(input string tag, input logic [63:0] actual, input logic [63:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic mgmt(input logic [3:0] op, input logic [23:0] idx, input bit v,
                      input logic [15:0] rif, input logic [3:0] ta,
                      input logic [7:0] tid, input logic [47:0] mac);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; {req_idx_hi, req_idx_lo} = idx;
    req_entry_valid = v; req_rif = rif; req_trap_act = ta; req_trap_id = tid; req_mac = mac;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [23:0] idx);
    mgmt(4'd0, idx, 1'b0, '0, '0, '0, '0);
  endtask

  task automatic look(input logic [23:0] idx);
    @(negedge clk);
    lk_valid = 1'b1; lk_index = idx;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset rsp_valid", rsp_valid, 0);
    chk("R8 reset lk_out_valid", lk_out_valid, 0);
    chk("R9 ready after reset", req_ready, 1);
  endtask

  task automatic t_write_read;
    mgmt(4'd1, 24'd5, 1'b1, 16'd10, 4'd2, 8'd1, 48'h0011_2233_4455);
    chk("R9 write rsp_valid", rsp_valid, 1);
    chk("R1 write status", rsp_status, 0);
    @(negedge clk);
    chk("R9 rsp one cycle only", rsp_valid, 0);
    rd(24'd5);
    chk("R1 read valid", rsp_entry_valid, 1);
    chk("R2 new entry active", rsp_active, 1);
    chk("R1 read rif", rsp_rif, 16'd10);
    chk("R12 read trap action", rsp_trap_act, 4'd2);
    chk("R12 read trap id", rsp_trap_id, 8'd1);
    chk("R1 read mac", rsp_mac, 48'h0011_2233_4455);
    mgmt(4'd2, 24'd5, 1'b0, '0, '0, '0, '0);
    chk("R2 read-clear returns old activity", rsp_active, 1);
    rd(24'd5);
    chk("R2 activity cleared", rsp_active, 0);
    rd(24'd6);
    chk("R5 unwritten entry valid", rsp_entry_valid, 0);
    chk("R5 unwritten entry mac zero", rsp_mac, 0);
  endtask

  task automatic t_lookup;
    look(24'd5);
    chk("R8 lookup out valid", lk_out_valid, 1);
    chk("R8 lookup hit", lk_hit, 1);
    chk("R8 lookup rif", lk_rif, 16'd10);
    chk("R8 lookup mac", lk_mac, 48'h0011_2233_4455);
    rd(24'd5);
    chk("R2 hit sets activity", rsp_active, 1);
    look(24'd6);
    chk("R8 miss on invalid", lk_hit, 0);
    chk("R8 miss fields zero", lk_rif, 0);
    look(24'd300);
    chk("R6 lookup out of range misses", lk_hit, 0);
  endtask

  task automatic t_cond_write;
    mgmt(4'd3, 24'd5, 1'b1, 16'd20, 4'd1, 8'd0, 48'hAA);
    chk("R3 dropped write status ok", rsp_status, 0);
    rd(24'd5);
    chk("R3 dropped write keeps rif", rsp_rif, 16'd10);
    mgmt(4'd2, 24'd5, 1'b0, '0, '0, '0, '0);
    mgmt(4'd3, 24'd5, 1'b1, 16'd20, 4'd1, 8'd0, 48'hAA);
    rd(24'd5);
    chk("R3 idle write applies rif", rsp_rif, 16'd20);
    chk("R3 idle write sets activity", rsp_active, 1);
  endtask

  task automatic t_errors;
    mgmt(4'd1, 24'd5, 1'b1, 16'(RIF_LIMIT), 4'd0, 8'd0, 48'h1);
    chk("R7 rif at limit rejected", rsp_status, 2);
    rd(24'd5);
    chk("R7 entry unchanged", rsp_rif, 16'd20);
    mgmt(4'd1, 24'd7, 1'b1, 16'(RIF_LIMIT - 1), 4'd0, 8'd0, 48'h1);
    chk("R7 rif below limit ok", rsp_status, 0);
    mgmt(4'd1, 24'd8, 1'b1, 16'd1, 4'd5, 8'd0, 48'h1);
    chk("R12 trap action 5 rejected", rsp_status, 2);
    mgmt(4'd1, 24'd8, 1'b1, 16'd1, 4'd4, 8'd2, 48'h1);
    chk("R12 trap id 2 rejected", rsp_status, 2);
    rd(24'd8);
    chk("R12 rejected entry stays invalid", rsp_entry_valid, 0);
    mgmt(4'd7, 24'd5, 1'b0, '0, '0, '0, '0);
    chk("R1 undefined opcode error", rsp_status, 2);
    mgmt(4'd1, 24'h01_0000, 1'b1, 16'd1, 4'd0, 8'd0, 48'h1);
    chk("R6 high index part out of range", rsp_status, 2);
    mgmt(4'd1, 24'd256, 1'b1, 16'd1, 4'd0, 8'd0, 48'h1);
    chk("R6 index equal depth", rsp_status, 2);
    mgmt(4'd1, 24'd255, 1'b1, 16'd33, 4'd3, 8'd0, 48'hBEEF);
    chk("R6 last index ok", rsp_status, 0);
    rd(24'd255);
    chk("R6 last index rif", rsp_rif, 16'd33);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'd2; {req_idx_hi, req_idx_lo} = 24'd5;
    lk_valid = 1'b1; lk_index = 24'd5;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; lk_valid = 1'b0;
    chk("R10 lookup hit in collision", lk_hit, 1);
    rd(24'd5);
    chk("R10 lookup wins over clear", rsp_active, 1);
  endtask

  task automatic t_quarantine;
    mgmt(4'd1, 24'd9, 1'b1, 16'd9, 4'd0, 8'd0, 48'h9);
    mgmt(4'd1, 24'd5, 1'b0, '0, '0, '0, '0);
    chk("R4 invalidate status", rsp_status, 0);
    mgmt(4'd1, 24'd9, 1'b0, '0, '0, '0, '0);
    rd(24'd5);
    chk("R4 read during window retry", rsp_status, 1);
    chk("R4 retry data zero", rsp_rif, 0);
    look(24'd5);
    chk("R4 lookup misses in window", lk_hit, 0);
    mgmt(4'd1, 24'd9, 1'b1, 16'd77, 4'd0, 8'd0, 48'h77);
    chk("R4 write during window retry", rsp_status, 1);
    repeat (Q) @(posedge clk);
    rd(24'd5);
    chk("R4 released after window", rsp_status, 0);
    chk("R5 invalid entry valid flag", rsp_entry_valid, 0);
    chk("R5 invalid entry rif zero", rsp_rif, 0);
    rd(24'd9);
    chk("R11 second window still running", rsp_status, 1);
    repeat (Q) @(posedge clk);
    rd(24'd9);
    chk("R11 second window released", rsp_status, 0);
    chk("R4 retried write had no effect", rsp_entry_valid, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_lookup();
    t_cond_write();
    t_errors();
    t_same_cycle();
    t_quarantine();
    done = 1;
    finish_run();
  end
endmodule